// File: doc/BRIEF.md
# Segment Register with Hidden Descriptor Cache

This block is one segment register. Software sees only a 16-bit selector. Behind the selector sits a hidden copy of the selected descriptor: the segment base, the segment limit and the access byte. Writing a selector starts a descriptor fetch at once. The block reads the entry from either the global or the local descriptor table through a simple request/acknowledge read port, and loads the hidden copy when the fetch completes. No software step is needed.

After a load, every access supplies only a 16-bit offset. The block checks the offset against the cached limit and returns the 24-bit sum of the cached base and the offset, one cycle later. It never reads the table again for these accesses. One set of hidden fields serves whichever of the 16K possible segments was loaded last.

The selector layout is as follows:

- Bits 15:3 hold the table index.
- Bit 2 is the table flag: 0 selects the global table and 1 selects the local table.
- Bits 1:0 hold the requested privilege, which the block stores but does not interpret.

Top module: `seg_cache_unit`

## Requirements
- R1: After reset the following hold: `busy` and `mem_req` are 0, `sel_q` is 0, `xl_valid` and `xl_fault` are 0, and `xl_ready` is 1. The hidden base and limit are 0, so offset 0 translates to address 0 and any other offset faults.
- R2: A selector write while idle, to an entry inside the table limit, raises `busy` on the next clock edge and starts reads. Bit 2 of the selector picks the table: 0 for the global table and 1 for the local table.
- R3: The entry address is the table base plus index×8, modulo 2^24. The four 16-bit reads go to entry+0, +2, +4 and +6, in that order.
- R4: Descriptor word layout: word 0 is the limit, word 1 is base[15:0], and word 2 carries base[23:16] in its low byte and the access byte in its high byte. Word 3 is discarded. On the fourth acknowledge the hidden fields and `sel_q` take the new values, `busy` falls, and `ld_done` pulses for one cycle.
- R5: If index×8+7 exceeds the selected table limit, no read is issued and `busy` stays low. `ld_fault` pulses on the next edge, and `sel_q`, `seg_attr`, the base and the limit keep their previous values.
- R6: A selector write while `busy` is high is ignored. The fetch in progress finishes with its own selector.
- R7: A request accepted while not busy, with offset ≤ cached limit, gives `xl_valid`=1 one cycle later. `xl_addr` then equals the cached base plus the offset, modulo 2^24.
- R8: An accepted request with offset > cached limit gives `xl_fault`=1 and `xl_valid`=0 one cycle later.
- R9: While `busy` is high, `xl_ready` is 0 and a request produces neither `xl_valid` nor `xl_fault`.
- R10: Once `mem_req` is raised, it and `mem_addr` stay unchanged until `mem_ack`. The read data is taken in the cycle that `mem_ack` is high.
- R11: Translation never causes a table read. `mem_req` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Write strobe for a new selector |
| sel_wdata | input | 16 | Selector value: index [15:3], table flag [2], privilege [1:0] |
| gtab_base | input | 24 | Global table base address |
| gtab_limit | input | 16 | Global table limit (last valid byte offset) |
| ltab_base | input | 24 | Local table base address |
| ltab_limit | input | 16 | Local table limit |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 24 | Table read byte address (even) |
| mem_ack | input | 1 | Read acknowledge; data is valid in the same cycle |
| mem_rdata | input | 16 | Read data word |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle pulse: the descriptor was loaded |
| ld_fault | output | 1 | One-cycle pulse: the selector was rejected by the table limit |
| sel_q | output | 16 | Current visible selector |
| seg_attr | output | 8 | Cached access byte |
| xl_req | input | 1 | Translation request |
| xl_off | input | 16 | Offset to translate |
| xl_ready | output | 1 | Requests are accepted (not busy) |
| xl_valid | output | 1 | Translated address is valid |
| xl_fault | output | 1 | Offset exceeded the cached limit |
| xl_addr | output | 24 | Translated physical address |

## Verification
A corrupted hidden base shows on `xl_addr` one cycle after the next accepted offset. A corrupted cached limit shows as a wrong choice between `xl_valid` and `xl_fault` at the limit boundary in that same cycle. A wrong entry address or word order shows on `mem_addr` at the first request of a fetch, and a late commit shows as `busy` staying high past the fourth acknowledge. A rejected load that still touched the cache shows on `sel_q` and `seg_attr` at once, and on the translation of a boundary offset right after.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int PA_W       = 24;
    localparam int OFF_W      = 16;
    localparam int WORD_W     = 16;
    localparam int IDX_W      = 13;
    localparam int ACC_W      = 8;
    localparam int DESC_WORDS = 4;
    localparam int CNT_W      = $clog2(DESC_WORDS);
    localparam int SEL_W      = IDX_W + 3;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ti;
        logic [1:0]       rpl;
    } sel_t;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] lim;
    } desc_t;

    typedef enum logic {F_IDLE, F_FETCH} fstate_e;
endpackage

// File: rtl/seg_fetch_ctl.sv
module seg_fetch_ctl
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr_i,
    input  sel_t              sel_i,
    input  logic [PA_W-1:0]   gbase_i,
    input  logic [OFF_W-1:0]  glim_i,
    input  logic [PA_W-1:0]   lbase_i,
    input  logic [OFF_W-1:0]  llim_i,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [PA_W-1:0]   mem_addr_o,
    output logic              busy_o,
    output logic              commit_o,
    output sel_t              pend_sel_o,
    output desc_t             new_desc_o,
    output logic              ld_done_o,
    output logic              ld_fault_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DESC_WORDS - 1);

    typedef struct packed {
        fstate_e                           st;
        logic [CNT_W-1:0]                  cnt;
        logic [PA_W-1:0]                   entry;
        sel_t                              pend;
        logic [DESC_WORDS-2:0][WORD_W-1:0] words;
        logic                              done;
        logic                              fault;
    } fetch_t;

    fetch_t r_q, r_d;

    logic [PA_W-1:0]  tab_base;
    logic [OFF_W-1:0] tab_lim;
    logic [OFF_W-1:0] span_end;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        tab_base  = sel_i.ti ? lbase_i : gbase_i;
        tab_lim   = sel_i.ti ? llim_i  : glim_i;
        span_end  = OFF_W'({sel_i.idx, 3'b111});
        commit_o  = 1'b0;
        unique case (r_q.st)
            F_IDLE: begin
                if (sel_wr_i) begin
                    if (span_end > tab_lim) begin
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.st    = F_FETCH;
                        r_d.cnt   = '0;
                        r_d.entry = tab_base + PA_W'({sel_i.idx, 3'b000});
                        r_d.pend  = sel_i;
                    end
                end
            end
            F_FETCH: begin
                if (mem_ack_i) begin
                    for (int k = 0; k < DESC_WORDS - 1; k++) begin
                        if (r_q.cnt == CNT_W'(k)) r_d.words[k] = mem_rdata_i;
                    end
                    if (r_q.cnt == LAST) begin
                        r_d.st   = F_IDLE;
                        r_d.done = 1'b1;
                        commit_o = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o          = (r_q.st == F_FETCH);
    assign mem_req_o       = busy_o;
    assign mem_addr_o      = r_q.entry + PA_W'({r_q.cnt, 1'b0});
    assign pend_sel_o      = r_q.pend;
    assign new_desc_o.lim  = r_q.words[0];
    assign new_desc_o.base = {r_q.words[2][7:0], r_q.words[1]};
    assign new_desc_o.acc  = r_q.words[2][15:8];
    assign ld_done_o       = r_q.done;
    assign ld_fault_o      = r_q.fault;
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  commit_i,
    input  sel_t  pend_sel_i,
    input  desc_t new_desc_i,
    output sel_t  sel_o,
    output desc_t desc_o
);
    typedef struct packed {
        sel_t  sel;
        desc_t desc;
    } cache_t;

    cache_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (commit_i) begin
            c_d.sel  = pend_sel_i;
            c_d.desc = new_desc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sel_o  = c_q.sel;
    assign desc_o = c_q.desc;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             busy_i,
    input  desc_t            desc_i,
    output logic             valid_o,
    output logic             fault_o,
    output logic [PA_W-1:0]  addr_o
);
    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] addr;
    } xl_t;

    xl_t x_q, x_d;
    logic take;
    logic in_range;

    always_comb begin
        take      = req_i && !busy_i;
        in_range  = (off_i <= desc_i.lim);
        x_d.valid = take && in_range;
        x_d.fault = take && !in_range;
        x_d.addr  = x_d.valid ? (desc_i.base + PA_W'(off_i)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign valid_o = x_q.valid;
    assign fault_o = x_q.fault;
    assign addr_o  = x_q.addr;
endmodule

// File: rtl/seg_cache_unit.sv
module seg_cache_unit
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic [PA_W-1:0]   gtab_base,
    input  logic [OFF_W-1:0]  gtab_limit,
    input  logic [PA_W-1:0]   ltab_base,
    input  logic [OFF_W-1:0]  ltab_limit,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              ld_done,
    output logic              ld_fault,
    output logic [SEL_W-1:0]  sel_q,
    output logic [ACC_W-1:0]  seg_attr,
    input  logic              xl_req,
    input  logic [OFF_W-1:0]  xl_off,
    output logic              xl_ready,
    output logic              xl_valid,
    output logic              xl_fault,
    output logic [PA_W-1:0]   xl_addr
);
    logic             commit;
    sel_t             pend_sel;
    desc_t            new_desc;
    sel_t             cur_sel;
    desc_t            cur_desc;
    logic [OFF_W-1:0] cur_lim;

    seg_fetch_ctl u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr_i   (sel_wr),
        .sel_i      (sel_t'(sel_wdata)),
        .gbase_i    (gtab_base),
        .glim_i     (gtab_limit),
        .lbase_i    (ltab_base),
        .llim_i     (ltab_limit),
        .mem_ack_i  (mem_ack),
        .mem_rdata_i(mem_rdata),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .busy_o     (busy),
        .commit_o   (commit),
        .pend_sel_o (pend_sel),
        .new_desc_o (new_desc),
        .ld_done_o  (ld_done),
        .ld_fault_o (ld_fault)
    );

    seg_desc_cache u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .pend_sel_i(pend_sel),
        .new_desc_i(new_desc),
        .sel_o     (cur_sel),
        .desc_o    (cur_desc)
    );

    seg_xlate u_xlate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (xl_req),
        .off_i  (xl_off),
        .busy_i (busy),
        .desc_i (cur_desc),
        .valid_o(xl_valid),
        .fault_o(xl_fault),
        .addr_o (xl_addr)
    );

    assign sel_q    = cur_sel;
    assign seg_attr = cur_desc.acc;
    assign cur_lim  = cur_desc.lim;
    assign xl_ready = !busy;
endmodule

// File: rtl/seg_cache_unit_chk.sv
module seg_cache_unit_chk
    import seg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sel_wr,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [PA_W-1:0]  mem_addr,
    input logic             busy,
    input logic             ld_done,
    input logic             ld_fault,
    input logic [SEL_W-1:0] sel_q,
    input logic             xl_req,
    input logic [OFF_W-1:0] xl_off,
    input logic             xl_valid,
    input logic             xl_fault,
    input logic [OFF_W-1:0] cur_lim
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_wr));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> !busy && $past(busy) && $past(mem_ack));

    assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault |-> !busy && $stable(sel_q));

    assert_ignore_busy_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_wr && !mem_ack) |=> $stable(sel_q));

    assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> $past(xl_off) <= $past(cur_lim));

    assert_out_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> !xl_valid && ($past(xl_off) > $past(cur_lim)));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && busy) |=> !xl_valid && !xl_fault);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

    assert_no_xl_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind seg_cache_unit seg_cache_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_wr  (sel_wr),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .busy    (busy),
    .ld_done (ld_done),
    .ld_fault(ld_fault),
    .sel_q   (sel_q),
    .xl_req  (xl_req),
    .xl_off  (xl_off),
    .xl_valid(xl_valid),
    .xl_fault(xl_fault),
    .cur_lim (cur_lim)
);

// File: tb/seg_cache_unit_test.sv
module seg_cache_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic [23:0] gtab_base = 24'h012340;
    logic [15:0] gtab_limit = 16'h03FF;
    logic [23:0] ltab_base = 24'hFFFF80;
    logic [15:0] ltab_limit = 16'h00FF;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, ld_done, ld_fault, xl_ready, xl_valid, xl_fault;
    logic [15:0] sel_q;
    logic [7:0]  seg_attr;
    logic        xl_req = 1'b0;
    logic [15:0] xl_off = '0;
    logic [23:0] xl_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit force_hi = 0;
    int wait_cnt = 0;
    int rd_n = 0;
    logic [23:0] rd_addr [8];

    logic [15:0] exp_sel = '0;
    logic [23:0] exp_base = '0;
    logic [15:0] exp_lim = '0;
    logic [7:0]  exp_acc = '0;

    always #4 clk = ~clk;

    seg_cache_unit uut (.*);

    function automatic logic [15:0] memword(input logic [23:0] a);
        logic [15:0] w;
        w = (a[15:0] * 16'hA5B3) ^ {a[23:16], a[23:16]} ^ 16'h3C5A;
        if (force_hi && a[2:1] == 2'd2) w[7:0] = 8'hFF;
        return w;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                mem_rdata = memword(mem_addr);
                if (rd_n < 8) rd_addr[rd_n] = mem_addr;
                rd_n++;
                wait_cnt = int'($urandom % 3);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xl(input logic [15:0] off);
        bit ok;
        logic [23:0] ea;
        @(negedge clk);
        xl_req = 1'b1;
        xl_off = off;
        @(negedge clk);
        xl_req = 1'b0;
        ok = (off <= exp_lim);
        ea = exp_base + {8'h00, off};
        if (ok) begin
            check(xl_valid === 1'b1 && xl_fault === 1'b0, "R7", "valid in range", {xl_valid, xl_fault}, 2'b10);
            check(xl_addr === ea, "R7", "translated address", xl_addr, ea);
        end else begin
            check(xl_fault === 1'b1 && xl_valid === 1'b0, "R8", "fault over limit", {xl_valid, xl_fault}, 2'b01);
        end
    endtask

    task automatic do_load(input logic [15:0] s, input bit poke);
        logic [23:0] tb;
        logic [15:0] tl, span;
        logic [23:0] e;
        logic [15:0] w0, w1, w2;
        int t;
        tb = s[2] ? ltab_base : gtab_base;
        tl = s[2] ? ltab_limit : gtab_limit;
        span = {s[15:3], 3'b111};
        e = tb + {8'h00, s[15:3], 3'b000};
        rd_n = 0;
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = s;
        @(negedge clk);
        sel_wr = 1'b0;
        if (span > tl) begin
            check(ld_fault === 1'b1, "R5", "reject pulse", ld_fault, 1);
            check(busy === 1'b0, "R5", "no fetch started", busy, 0);
            @(negedge clk);
            check(rd_n == 0, "R5", "no reads issued", rd_n, 0);
            check(sel_q === exp_sel, "R5", "selector kept", sel_q, exp_sel);
            check(seg_attr === exp_acc, "R5", "access kept", seg_attr, exp_acc);
        end else begin
            check(busy === 1'b1, "R2", "busy after write", busy, 1);
            if (poke) begin
                check(xl_ready === 1'b0, "R9", "not ready while busy", xl_ready, 0);
                sel_wr = 1'b1;
                sel_wdata = ~s;
                xl_req = 1'b1;
                xl_off = 16'h0000;
                @(negedge clk);
                sel_wr = 1'b0;
                xl_req = 1'b0;
                check(xl_valid === 1'b0 && xl_fault === 1'b0, "R9", "stalled request silent",
                      {xl_valid, xl_fault}, 0);
            end
            t = 0;
            while (busy === 1'b1 && t < 200) begin
                @(negedge clk);
                t++;
            end
            check(ld_done === 1'b1, "R4", "load done pulse", ld_done, 1);
            check(rd_n == 4, "R3", "four reads", rd_n, 4);
            for (int k = 0; k < 4; k++) begin
                logic [23:0] ek;
                ek = e + 24'(2 * k);
                check(rd_addr[k] === ek, "R3", "read address order", rd_addr[k], ek);
            end
            w0 = memword(e);
            w1 = memword(e + 24'd2);
            w2 = memword(e + 24'd4);
            exp_sel = s;
            exp_lim = w0;
            exp_base = {w2[7:0], w1};
            exp_acc = w2[15:8];
            check(sel_q === exp_sel, poke ? "R6" : "R4", "selector committed", sel_q, exp_sel);
            check(seg_attr === exp_acc, "R4", "access byte", seg_attr, exp_acc);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && mem_req === 1'b0, "R1", "idle after reset", {busy, mem_req}, 0);
        check(sel_q === 16'h0 && xl_valid === 1'b0 && xl_fault === 1'b0, "R1", "outputs after reset",
              {sel_q, xl_valid, xl_fault}, 0);
        check(xl_ready === 1'b1, "R1", "ready after reset", xl_ready, 1);
        xl(16'h0000);
        xl(16'h0001);

        do_load({13'd5, 1'b0, 2'b01}, 1'b1);
        xl(16'h0000);
        xl(exp_lim);
        if (exp_lim != 16'hFFFF) xl(exp_lim + 16'd1);
        xl(16'hFFFF);

        do_load({13'd127, 1'b0, 2'b00}, 1'b0);
        do_load({13'd128, 1'b0, 2'b00}, 1'b0);
        xl(exp_lim);
        do_load({13'd32, 1'b1, 2'b11}, 1'b0);
        do_load({13'd31, 1'b1, 2'b10}, 1'b1);
        xl(exp_lim);

        force_hi = 1'b1;
        do_load({13'd9, 1'b0, 2'b00}, 1'b0);
        xl(exp_lim);
        xl(16'h0000);
        force_hi = 1'b0;

        for (int i = 0; i < 40; i++) begin
            logic [15:0] s;
            s = 16'($urandom);
            s[15:3] = 13'($urandom % 160);
            do_load(s, 1'($urandom));
            for (int j = 0; j < 3; j++) begin
                logic [16:0] r;
                r = 17'($urandom) % ({1'b0, exp_lim} + 17'd2);
                xl((r > 17'h0FFFF) ? 16'hFFFF : r[15:0]);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule